// File: doc/BRIEF.md
# Snooping I/O Coherence Controller for a Direct-Mapped Cache

This block keeps a direct-mapped data cache consistent with I/O transfers that move data between devices and main memory on a shared bus. It holds two identical tag arrays. The processor side looks up one of them. The other copy watches the bus. A bus snoop and a processor lookup can therefore both be resolved in the same clock cycle.

Device-to-memory transfers are called input. When an input hits a valid line, the cached word is overwritten with the bus data, and memory still takes the write. Memory-to-device transfers are called output. When an output hits a line in write-through mode, the line is dropped and memory answers. In write-back mode, a dirty hit first holds memory off the bus for one cycle. It then drives the cached word and drops the line. A clean hit in write-back mode is dropped like a write-through hit. A miss leaves the cache untouched.

On the processor side there are three operations: line fill, word write and word read. Processor miss handling beyond the tag update is left to the surrounding cache. When a processor write or fill targets the same line that a snoop modifies in the same cycle, the controller asks the processor to retry. The snoop takes effect.

Top module: `snoop_coherence_ctrl`

## Requirements
- R1: After reset every line is invalid, and `bus_inhibit_o`, `bus_data_valid_o` and `cpu_retry_o` are 0.
- R2: A fill (cpu_fill_i=1) at the edge ending its cycle installs the address tag and all words of `cpu_line_i` (word w at bits w*32+31:w*32) as a valid, clean line. A read then hits and returns word address bits [3:2]. A read with a different tag (bits [31:10]) at the same index (bits [9:4]) misses.
- R3: A bus input (bus_write_i=1) whose address hits a valid line overwrites that word at the ending edge. The other words of the line are unchanged, and `bus_inhibit_o` stays 0.
- R4: A bus output (bus_write_i=0) hitting a line in write-through mode (wb_mode_i=0), or hitting a clean line in write-back mode, invalidates the line at the ending edge. No inhibit and no data drive follow.
- R5: A bus output hitting a dirty line in write-back mode sets `bus_inhibit_o` for exactly the one cycle after the request. In the cycle after that, `bus_data_valid_o` is 1 and `bus_data_o` carries the addressed cached word. The line is invalid afterwards.
- R6: A bus transfer that misses changes no line and causes no inhibit or drive.
- R7: A processor write (cpu_we_i=1) hitting a valid line updates the addressed word. It marks the line dirty only when wb_mode_i=1.
- R8: When a snoop hit modifies a line and a processor write or fill targets the same index in the same cycle, `cpu_retry_o` is 1 in that cycle. The processor operation is discarded and the snoop effect is applied.
- R9: A processor read of a different line in the same cycle as a snoop hit returns its hit and data in that cycle without retry.
- R10: Both tag copies receive every valid, dirty and tag update in the same cycle. A dirty mark made through the processor side is therefore seen by the next snoop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wb_mode_i | input | 1 | 1 selects write-back, 0 write-through |
| cpu_req_i | input | 1 | Processor operation valid |
| cpu_we_i | input | 1 | Processor word write (when not filling) |
| cpu_fill_i | input | 1 | Processor line fill |
| cpu_addr_i | input | 32 | Processor byte address |
| cpu_wdata_i | input | 32 | Processor write word |
| cpu_line_i | input | 128 | Fill line data |
| cpu_hit_o | output | 1 | Processor lookup hit |
| cpu_rdata_o | output | 32 | Word read from the addressed line |
| cpu_retry_o | output | 1 | Processor operation dropped, retry |
| bus_valid_i | input | 1 | Bus transfer present this cycle |
| bus_write_i | input | 1 | 1 input (device to memory), 0 output |
| bus_addr_i | input | 32 | Bus byte address |
| bus_wdata_i | input | 32 | Bus input data |
| bus_inhibit_o | output | 1 | Memory must not drive this cycle |
| bus_data_valid_o | output | 1 | Cache drives bus_data_o this cycle |
| bus_data_o | output | 32 | Word supplied from cache |

## Verification
The checker assumes that the bus issues no new transfer while an inhibit and drive sequence is running. It also assumes that the mode input stays steady around a write-back output request. The bench keeps to both: it changes the mode only between operations, and it waits for each supply sequence to end before it drives the bus again. Inputs change on the falling edge only, so every snoop and processor operation is a single clean cycle. The checker can then compare the two tag copies wherever both look up the same index.

// File: rtl/snp_pkg.sv
package snp_pkg;

   typedef enum logic [1:0] {
      TOP_NONE  = 2'd0,
      TOP_FILL  = 2'd1,
      TOP_DIRTY = 2'd2
   } tag_op_e;

   typedef enum logic [1:0] {
      SEQ_IDLE    = 2'd0,
      SEQ_INHIBIT = 2'd1,
      SEQ_DRIVE   = 2'd2
   } seq_state_e;

endpackage

// File: rtl/snp_tag_copy.sv
module snp_tag_copy
   import snp_pkg::*;
#(
   parameter int LINES = 64,
   parameter int TAG_W = 22,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  tag_op_e          upd_op_i,
   input  logic [IDX_W-1:0] upd_idx_i,
   input  logic [TAG_W-1:0] upd_tag_i,
   input  logic             clr_i,
   input  logic [IDX_W-1:0] clr_idx_i,
   input  logic [IDX_W-1:0] look_idx_i,
   output logic             look_valid_o,
   output logic             look_dirty_o,
   output logic [TAG_W-1:0] look_tag_o
);

   logic [LINES-1:0] valid_q;
   logic [LINES-1:0] dirty_q;
   logic [TAG_W-1:0] tag_q [LINES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         dirty_q <= '0;
      end else begin
         case (upd_op_i)
            TOP_FILL: begin
               valid_q[upd_idx_i] <= 1'b1;
               dirty_q[upd_idx_i] <= 1'b0;
            end
            TOP_DIRTY: dirty_q[upd_idx_i] <= 1'b1;
            default: ;
         endcase
         // snoop clear is applied last
         if (clr_i) begin
            valid_q[clr_idx_i] <= 1'b0;
            dirty_q[clr_idx_i] <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (upd_op_i == TOP_FILL) tag_q[upd_idx_i] <= upd_tag_i;
   end

   assign look_valid_o = valid_q[look_idx_i];
   assign look_dirty_o = dirty_q[look_idx_i];
   assign look_tag_o   = tag_q[look_idx_i];

endmodule

// File: rtl/snp_line_store.sv
module snp_line_store #(
   parameter int LINES  = 64,
   parameter int WORDS  = 4,
   parameter int DATA_W = 32,
   localparam int IDX_W  = $clog2(LINES),
   localparam int WSEL_W = $clog2(WORDS),
   localparam int LINE_W = WORDS * DATA_W
) (
   input  logic              clk,
   input  logic              fill_en_i,
   input  logic              cpu_wr_en_i,
   input  logic [IDX_W-1:0]  cpu_idx_i,
   input  logic [WSEL_W-1:0] cpu_word_i,
   input  logic [DATA_W-1:0] cpu_wdata_i,
   input  logic [LINE_W-1:0] fill_line_i,
   input  logic              bus_wr_en_i,
   input  logic [IDX_W-1:0]  bus_idx_i,
   input  logic [WSEL_W-1:0] bus_word_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] cpu_rdata_o,
   output logic [DATA_W-1:0] snp_rdata_o
);

   logic [DATA_W-1:0] mem_q [LINES][WORDS];

   always_ff @(posedge clk) begin
      if (fill_en_i) begin
         for (int w = 0; w < WORDS; w++) begin
            mem_q[cpu_idx_i][w] <= fill_line_i[w*DATA_W +: DATA_W];
         end
      end else if (cpu_wr_en_i) begin
         mem_q[cpu_idx_i][cpu_word_i] <= cpu_wdata_i;
      end
      if (bus_wr_en_i) mem_q[bus_idx_i][bus_word_i] <= bus_wdata_i;
   end

   assign cpu_rdata_o = mem_q[cpu_idx_i][cpu_word_i];
   assign snp_rdata_o = mem_q[bus_idx_i][bus_word_i];

endmodule

// File: rtl/snp_supply_seq.sv
module snp_supply_seq
   import snp_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [DATA_W-1:0] word_i,
   output logic              busy_o,
   output logic              inhibit_o,
   output logic              drive_o,
   output logic [DATA_W-1:0] data_o
);

   seq_state_e        state_q;
   logic [DATA_W-1:0] hold_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         hold_q  <= '0;
      end else begin
         case (state_q)
            SEQ_IDLE: if (start_i) begin
               state_q <= SEQ_INHIBIT;
               hold_q  <= word_i;
            end
            SEQ_INHIBIT: state_q <= SEQ_DRIVE;
            default:     state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign busy_o    = (state_q != SEQ_IDLE);
   assign inhibit_o = (state_q == SEQ_INHIBIT);
   assign drive_o   = (state_q == SEQ_DRIVE);
   assign data_o    = drive_o ? hold_q : '0;

endmodule

// File: rtl/snoop_coherence_ctrl.sv
module snoop_coherence_ctrl
   import snp_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int LINES  = 64,
   parameter int WORDS  = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wb_mode_i,
   input  logic                    cpu_req_i,
   input  logic                    cpu_we_i,
   input  logic                    cpu_fill_i,
   input  logic [ADDR_W-1:0]       cpu_addr_i,
   input  logic [DATA_W-1:0]       cpu_wdata_i,
   input  logic [WORDS*DATA_W-1:0] cpu_line_i,
   output logic                    cpu_hit_o,
   output logic [DATA_W-1:0]       cpu_rdata_o,
   output logic                    cpu_retry_o,
   input  logic                    bus_valid_i,
   input  logic                    bus_write_i,
   input  logic [ADDR_W-1:0]       bus_addr_i,
   input  logic [DATA_W-1:0]       bus_wdata_i,
   output logic                    bus_inhibit_o,
   output logic                    bus_data_valid_o,
   output logic [DATA_W-1:0]       bus_data_o
);

   localparam int BYTE_W = $clog2(DATA_W / 8);
   localparam int WSEL_W = $clog2(WORDS);
   localparam int OFF_W  = BYTE_W + WSEL_W;
   localparam int IDX_W  = $clog2(LINES);
   localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
   localparam int COPIES = 2;

   generate
      if (LINES < 2 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
         $error("LINES must be a power of two, at least 2");
      end
      if (WORDS < 2 || (WORDS & (WORDS - 1)) != 0) begin : g_bad_words
         $error("WORDS must be a power of two, at least 2");
      end
      if (DATA_W < 16 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data
         $error("DATA_W must be a power of two, at least 16");
      end
      if (TAG_W < 1) begin : g_bad_tag
         $error("ADDR_W too small for LINES and WORDS");
      end
   endgenerate

   // address fields
   logic [IDX_W-1:0]  cpu_idx, bus_idx;
   logic [WSEL_W-1:0] cpu_word, bus_word;
   logic [TAG_W-1:0]  cpu_tag, bus_tag;

   assign cpu_idx  = cpu_addr_i[OFF_W +: IDX_W];
   assign bus_idx  = bus_addr_i[OFF_W +: IDX_W];
   assign cpu_word = cpu_addr_i[BYTE_W +: WSEL_W];
   assign bus_word = bus_addr_i[BYTE_W +: WSEL_W];
   assign cpu_tag  = cpu_addr_i[ADDR_W-1 -: TAG_W];
   assign bus_tag  = bus_addr_i[ADDR_W-1 -: TAG_W];

   // tag copies: 0 serves the processor, 1 serves the bus
   logic [COPIES-1:0] cp_valid, cp_dirty;
   logic [TAG_W-1:0]  cp_tag  [COPIES];
   logic [IDX_W-1:0]  look_idx [COPIES];
   tag_op_e           tag_op;
   logic              snp_clr;

   assign look_idx[0] = cpu_idx;
   assign look_idx[1] = bus_idx;

   generate
      for (genvar c = 0; c < COPIES; c++) begin : g_copy
         snp_tag_copy #(
            .LINES(LINES),
            .TAG_W(TAG_W)
         ) u_tags (
            .clk          (clk),
            .rst_n        (rst_n),
            .upd_op_i     (tag_op),
            .upd_idx_i    (cpu_idx),
            .upd_tag_i    (cpu_tag),
            .clr_i        (snp_clr),
            .clr_idx_i    (bus_idx),
            .look_idx_i   (look_idx[c]),
            .look_valid_o (cp_valid[c]),
            .look_dirty_o (cp_dirty[c]),
            .look_tag_o   (cp_tag[c])
         );
      end
   endgenerate

   // snoop decision
   logic seq_busy, seq_start;
   logic p_hit, s_hit, clash, fill_go, wr_go;
   logic [DATA_W-1:0] snp_word;

   assign p_hit = cp_valid[0] && (cp_tag[0] == cpu_tag);
   assign s_hit = bus_valid_i && !seq_busy && cp_valid[1] && (cp_tag[1] == bus_tag);

   assign clash   = s_hit && cpu_req_i && (cpu_we_i || cpu_fill_i) && (cpu_idx == bus_idx);
   assign fill_go = cpu_req_i && cpu_fill_i && !clash;
   assign wr_go   = cpu_req_i && cpu_we_i && !cpu_fill_i && p_hit && !clash;

   always_comb begin
      tag_op = TOP_NONE;
      if (fill_go)                tag_op = TOP_FILL;
      else if (wr_go && wb_mode_i) tag_op = TOP_DIRTY;
   end

   assign snp_clr   = s_hit && !bus_write_i;
   assign seq_start = snp_clr && wb_mode_i && cp_dirty[1];

   snp_line_store #(
      .LINES (LINES),
      .WORDS (WORDS),
      .DATA_W(DATA_W)
   ) u_store (
      .clk         (clk),
      .fill_en_i   (fill_go),
      .cpu_wr_en_i (wr_go),
      .cpu_idx_i   (cpu_idx),
      .cpu_word_i  (cpu_word),
      .cpu_wdata_i (cpu_wdata_i),
      .fill_line_i (cpu_line_i),
      .bus_wr_en_i (s_hit && bus_write_i),
      .bus_idx_i   (bus_idx),
      .bus_word_i  (bus_word),
      .bus_wdata_i (bus_wdata_i),
      .cpu_rdata_o (cpu_rdata_o),
      .snp_rdata_o (snp_word)
   );

   snp_supply_seq #(
      .DATA_W(DATA_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (seq_start),
      .word_i    (snp_word),
      .busy_o    (seq_busy),
      .inhibit_o (bus_inhibit_o),
      .drive_o   (bus_data_valid_o),
      .data_o    (bus_data_o)
   );

   assign cpu_hit_o   = cpu_req_i && !cpu_fill_i && p_hit;
   assign cpu_retry_o = clash;

endmodule

module snp_coherence_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wb_mode_i,
   input logic       bus_valid_i,
   input logic       cpu_req_i,
   input logic       cpu_we_i,
   input logic       cpu_fill_i,
   input logic       cpu_retry_o,
   input logic       bus_inhibit_o,
   input logic       bus_data_valid_o,
   input logic       same_idx,
   input logic [1:0] cp_valid,
   input logic [1:0] cp_dirty,
   input logic       tags_equal
);

   // R5
   inhibit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_inhibit_o |=> (!bus_inhibit_o && bus_data_valid_o));

   // R5
   drive_follows_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_data_valid_o |-> $past(bus_inhibit_o));

   // R5
   inhibit_drive_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_inhibit_o && bus_data_valid_o));

   // R4
   wt_never_inhibits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_inhibit_o |-> $past(wb_mode_i));

   // R8
   retry_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_retry_o |-> (bus_valid_i && cpu_req_i && (cpu_we_i || cpu_fill_i)));

   // R10
   copies_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
      same_idx |-> ((cp_valid[0] == cp_valid[1]) && (cp_dirty[0] == cp_dirty[1])
                    && (!cp_valid[0] || tags_equal)));

endmodule

bind snoop_coherence_ctrl snp_coherence_chk u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .wb_mode_i        (wb_mode_i),
   .bus_valid_i      (bus_valid_i),
   .cpu_req_i        (cpu_req_i),
   .cpu_we_i         (cpu_we_i),
   .cpu_fill_i       (cpu_fill_i),
   .cpu_retry_o      (cpu_retry_o),
   .bus_inhibit_o    (bus_inhibit_o),
   .bus_data_valid_o (bus_data_valid_o),
   .same_idx         (cpu_idx == bus_idx),
   .cp_valid         (cp_valid),
   .cp_dirty         (cp_dirty),
   .tags_equal       (cp_tag[0] == cp_tag[1])
);

// File: tb/snoop_coherence_ctrl_tb.sv
module snoop_coherence_ctrl_tb_top;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         wb_mode_i;
   logic         cpu_req_i, cpu_we_i, cpu_fill_i;
   logic [31:0]  cpu_addr_i, cpu_wdata_i;
   logic [127:0] cpu_line_i;
   logic         cpu_hit_o, cpu_retry_o;
   logic [31:0]  cpu_rdata_o;
   logic         bus_valid_i, bus_write_i;
   logic [31:0]  bus_addr_i, bus_wdata_i;
   logic         bus_inhibit_o, bus_data_valid_o;
   logic [31:0]  bus_data_o;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   snoop_coherence_ctrl dut_i (.*);

   localparam logic [2:0] OP_RD = 3'd0, OP_FILL = 3'd1, OP_WR = 3'd2,
                          OP_BIN = 3'd3, OP_BOUT = 3'd4;

   typedef struct packed {
      logic [2:0]  op;
      logic [31:0] addr;
      logic [31:0] data;
      logic        hit;
      logic [31:0] exp;
   } vec_t;

   // address = tag<<10 | index<<4 | word<<2 ; write-through mode
   localparam int NV = 15;
   localparam vec_t VEC [NV] = '{
      '{OP_RD,   32'h0048D058, 32'h0,        1'b0, 32'h0},        // R1 empty
      '{OP_FILL, 32'h0048D050, 32'h100,      1'b0, 32'h0},        // R2
      '{OP_RD,   32'h0048D058, 32'h0,        1'b1, 32'h102},      // R2
      '{OP_RD,   32'h0048D458, 32'h0,        1'b0, 32'h0},        // R2 tag differs
      '{OP_BIN,  32'h0048D054, 32'hAAAA0001, 1'b0, 32'h0},        // R3
      '{OP_RD,   32'h0048D054, 32'h0,        1'b1, 32'hAAAA0001}, // R3
      '{OP_RD,   32'h0048D05C, 32'h0,        1'b1, 32'h103},      // R3 other word
      '{OP_BIN,  32'h001DDC90, 32'h0000BEEF, 1'b0, 32'h0},        // R6 miss
      '{OP_RD,   32'h001DDC90, 32'h0,        1'b0, 32'h0},        // R6
      '{OP_WR,   32'h0048D050, 32'h55,       1'b0, 32'h0},        // R7
      '{OP_RD,   32'h0048D050, 32'h0,        1'b1, 32'h55},       // R7
      '{OP_BOUT, 32'h0048D450, 32'h0,        1'b0, 32'h0},        // R6 tag miss
      '{OP_RD,   32'h0048D050, 32'h0,        1'b1, 32'h55},       // R6
      '{OP_BOUT, 32'h0048D058, 32'h0,        1'b0, 32'h0},        // R4
      '{OP_RD,   32'h0048D050, 32'h0,        1'b0, 32'h0}         // R4
   };

   function automatic logic [31:0] mk(input int tg, input int ix, input int wd);
      return (tg << 10) | (ix << 4) | (wd << 2);
   endfunction

   function automatic logic [127:0] line_of(input logic [31:0] b);
      return {b + 32'd3, b + 32'd2, b + 32'd1, b};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic quiet();
      cpu_req_i = 0; cpu_we_i = 0; cpu_fill_i = 0;
      cpu_addr_i = '0; cpu_wdata_i = '0; cpu_line_i = '0;
      bus_valid_i = 0; bus_write_i = 0; bus_addr_i = '0; bus_wdata_i = '0;
   endtask

   task automatic set_cpu(input logic [2:0] op, input logic [31:0] a, input logic [31:0] d);
      cpu_req_i  = 1'b1;
      cpu_fill_i = (op == OP_FILL);
      cpu_we_i   = (op == OP_WR);
      cpu_addr_i = a;
      cpu_wdata_i = d;
      cpu_line_i = line_of(d);
   endtask

   task automatic set_bus(input bit wr, input logic [31:0] a, input logic [31:0] d);
      bus_valid_i = 1'b1; bus_write_i = wr; bus_addr_i = a; bus_wdata_i = d;
   endtask

   // one-cycle operation: apply at falling edge, release after rising edge
   task automatic finish_cycle();
      @(posedge clk); #1; quiet();
   endtask

   task automatic read_chk(input logic [31:0] a, input bit eh, input logic [31:0] ed, input string req);
      @(negedge clk); set_cpu(OP_RD, a, 0); #1;
      chk(cpu_hit_o == eh, req, {31'b0, cpu_hit_o}, {31'b0, eh});
      if (eh) chk(cpu_rdata_o == ed, req, cpu_rdata_o, ed);
      finish_cycle();
   endtask

   task automatic op(input logic [2:0] o, input logic [31:0] a, input logic [31:0] d);
      @(negedge clk);
      if (o == OP_BIN || o == OP_BOUT) set_bus(o == OP_BIN, a, d);
      else set_cpu(o, a, d);
      finish_cycle();
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         summary();
         $finish;
      end
   end

   initial begin
      quiet();
      wb_mode_i = 1'b0;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      chk(!bus_inhibit_o && !bus_data_valid_o, "R1", {30'b0, bus_inhibit_o, bus_data_valid_o}, 0);
      chk(!cpu_retry_o, "R1", {31'b0, cpu_retry_o}, 0);
      for (int i = 0; i < 64; i += 9) read_chk(mk(0, i, 0), 1'b0, 0, "R1");

      // vector table, write-through mode
      for (int v = 0; v < NV; v++) begin
         @(negedge clk);
         if (VEC[v].op == OP_BIN || VEC[v].op == OP_BOUT)
            set_bus(VEC[v].op == OP_BIN, VEC[v].addr, VEC[v].data);
         else
            set_cpu(VEC[v].op, VEC[v].addr, VEC[v].data);
         #1;
         if (VEC[v].op == OP_RD) begin
            chk(cpu_hit_o == VEC[v].hit, "R2/R3/R4/R6/R7 table hit", {31'b0, cpu_hit_o}, {31'b0, VEC[v].hit});
            if (VEC[v].hit) chk(cpu_rdata_o == VEC[v].exp, "R2/R3/R7 table data", cpu_rdata_o, VEC[v].exp);
         end
         finish_cycle();
         if (VEC[v].op == OP_BIN || VEC[v].op == OP_BOUT)
            chk(!bus_inhibit_o && !bus_data_valid_o, "R3/R4/R6 no inhibit",
                {30'b0, bus_inhibit_o, bus_data_valid_o}, 0);
      end

      // R7: write-through write leaves line clean, so a later write-back snoop only invalidates
      op(OP_FILL, mk('h50, 30, 0), 32'h500);
      op(OP_WR, mk('h50, 30, 0), 32'h5A);
      wb_mode_i = 1'b1;
      op(OP_BOUT, mk('h50, 30, 0), 0);
      chk(!bus_inhibit_o, "R7 WT write not dirty", {31'b0, bus_inhibit_o}, 0);
      @(posedge clk); #1;
      chk(!bus_data_valid_o, "R4 clean WB no drive", {31'b0, bus_data_valid_o}, 0);
      read_chk(mk('h50, 30, 0), 1'b0, 0, "R4 clean WB invalidated");

      // R5/R9/R10: dirty line in write-back mode supplies data
      op(OP_FILL, mk('h42, 12, 0), 32'h200);
      op(OP_FILL, mk('h300, 20, 0), 32'h300);
      op(OP_WR, mk('h42, 12, 1), 32'hD1);     // marks dirty via processor side
      @(negedge clk);
      set_bus(1'b0, mk('h42, 12, 1), 0);
      set_cpu(OP_RD, mk('h300, 20, 3), 0);
      #1;
      chk(cpu_hit_o && !cpu_retry_o, "R9 concurrent hit", {30'b0, cpu_hit_o, cpu_retry_o}, 32'h2);
      chk(cpu_rdata_o == 32'h303, "R9 concurrent data", cpu_rdata_o, 32'h303);
      finish_cycle();
      chk(bus_inhibit_o && !bus_data_valid_o, "R5 R10 inhibit cycle",
          {30'b0, bus_inhibit_o, bus_data_valid_o}, 32'h2);
      @(posedge clk); #1;
      chk(!bus_inhibit_o && bus_data_valid_o, "R5 drive cycle",
          {30'b0, bus_inhibit_o, bus_data_valid_o}, 32'h1);
      chk(bus_data_o == 32'hD1, "R5 supplied word", bus_data_o, 32'hD1);
      @(posedge clk); #1;
      chk(!bus_inhibit_o && !bus_data_valid_o, "R5 sequence ends",
          {30'b0, bus_inhibit_o, bus_data_valid_o}, 0);
      read_chk(mk('h42, 12, 1), 1'b0, 0, "R5 line invalidated");

      // R8: collisions, write-through mode
      wb_mode_i = 1'b0;
      op(OP_FILL, mk('h60, 40, 0), 32'h600);
      @(negedge clk);
      set_bus(1'b0, mk('h60, 40, 0), 0);
      set_cpu(OP_WR, mk('h60, 40, 2), 32'h99);
      #1;
      chk(cpu_retry_o, "R8 retry on invalidate clash", {31'b0, cpu_retry_o}, 1);
      finish_cycle();
      read_chk(mk('h60, 40, 2), 1'b0, 0, "R8 snoop invalidate wins");

      op(OP_FILL, mk('h61, 41, 0), 32'h610);
      @(negedge clk);
      set_bus(1'b1, mk('h61, 41, 2), 32'h77);
      set_cpu(OP_WR, mk('h61, 41, 2), 32'h88);
      #1;
      chk(cpu_retry_o, "R8 retry on input clash", {31'b0, cpu_retry_o}, 1);
      finish_cycle();
      read_chk(mk('h61, 41, 2), 1'b1, 32'h77, "R8 bus data kept");

      @(negedge clk);
      set_bus(1'b1, mk('h61, 41, 0), 32'h11);
      set_cpu(OP_FILL, mk('h62, 42, 0), 32'h620);
      #1;
      chk(!cpu_retry_o, "R8 no retry other index", {31'b0, cpu_retry_o}, 0);
      finish_cycle();
      read_chk(mk('h62, 42, 1), 1'b1, 32'h621, "R8 fill applied");

      done = 1'b1;
      summary();
      $finish;
   end

endmodule